// File: doc/BRIEF.md
# Single-Bit Static RAM with Complementary Outputs

A 256-word by 1-bit static memory. It has an 8-bit address, one data input, an active-low select and an active-high write enable. Two outputs present the addressed bit: one in true polarity and one inverted. Each output is modelled as a value plus its own enable, so a deselected instance drives nothing and can share a wired-OR net with other instances.

All inputs are sampled on the rising clock edge, and the outputs are registered at that same edge. A small state machine classifies each cycle into one of three states:
- `ST_IDLE` (inhibit): the select is high.
- `ST_READ`: selected, with write enable low.
- `ST_WRITE`: selected, with write enable high.

Every transition between these states is legal and depends only on the inputs sampled at the edge. The `ST_READ` → `ST_WRITE` transition at an unchanged address forms a read-modify-write. During a write, the outputs echo the data being stored rather than the old cell contents.

Top module: `bitram_cmp`

## Requirements
- R1: The array holds 256 independent 1-bit words selected by `addr` (0 to 255). A value written at one address is read back there, and writes to other addresses do not change it.
- R2: While `cs_n` is 1 at an edge, both `q_oe` and `qn_oe` are 0 after that edge and the array is left unchanged, whatever the levels of `we`, `addr` and `din`.
- R3: At an edge with `cs_n` = 0 and `we` = 1, the bit at `addr` takes the value of `din` at that edge.
- R4: At an edge with `cs_n` = 0 and `we` = 0, after that edge `q` equals the stored bit at `addr`, `qn` equals its complement, and both enables are 1.
- R5: At an edge with `cs_n` = 0 and `we` = 1, after that edge `q` equals `din` and `qn` equals `~din`, with both enables at 1.
- R6: Read-modify-write is supported. A selected read at address A followed in the next cycle by a selected write at A first shows the old bit, then the new bit. A later read of A returns the new bit.
- R7: `q_oe` and `qn_oe` are always equal, and whenever they are 1, `q` differs from `qn`.
- R8: Synchronous active-high `rst` clears both output enables (state `ST_IDLE`) after the edge. It does not alter the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling happens on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Select, active low |
| we | input | 1 | Write enable, active high |
| addr | input | 8 | Word address |
| din | input | 1 | Data to store |
| q | output | 1 | True-polarity output value |
| q_oe | output | 1 | Drive enable for `q` |
| qn | output | 1 | Inverted output value |
| qn_oe | output | 1 | Drive enable for `qn` |

## Verification
Several properties are checked on every cycle:
- The output enables follow the select one edge later, and the two enables never disagree.
- The enabled outputs are always complementary.
- A write echoes its data on the outputs.
- An unselected cycle leaves the whole array unchanged.
- A write lands at the sampled address.

Only the bench scenarios can show that data survives across other addresses and across reset, that a read returns what an earlier write stored, and the old-then-new order of a read-modify-write. A reference array drives randomized read and write traffic for these checks.

// File: rtl/bitram_pkg.sv
package bitram_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bitram_state_t;
endpackage

// File: rtl/bitram_ctrl.sv
module bitram_ctrl
    import bitram_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n_i,
    input  logic          we_i,
    output bitram_state_t st_d_o,
    output bitram_state_t st_q_o,
    output logic          wr_en_o,
    output logic          ld_en_o
);
    bitram_state_t st_d;
    bitram_state_t st_q;

    // next state: purely a function of the sampled controls
    always_comb begin
        unique case ({cs_n_i, we_i})
            2'b00:   st_d = ST_READ;
            2'b01:   st_d = ST_WRITE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // outputs of the machine
    always_comb begin
        wr_en_o = 1'b0;
        ld_en_o = 1'b0;
        unique case (st_d)
            ST_READ:  ld_en_o = 1'b1;
            ST_WRITE: begin
                ld_en_o = 1'b1;
                wr_en_o = !rst;
            end
            default: ;
        endcase
    end

    assign st_d_o = st_d;
    assign st_q_o = st_q;

    // R2: selection off at an edge means idle state after it
    assert_idle_on_deselect_R2: assert property (@(posedge clk) disable iff (rst)
        cs_n_i |=> (st_q == ST_IDLE));

    // R8: reset forces the idle state
    assert_reset_idle_R8: assert property (@(posedge clk)
        rst |=> (st_q == ST_IDLE));
endmodule

// File: rtl/bitram_array.sv
module bitram_array #(
    parameter int ADDR_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              din_i,
    output logic              rd_bit_o
);
    logic [DEPTH-1:0] cells;

    // no reset on the storage: contents persist through rst
    always_ff @(posedge clk) begin
        if (wr_en_i) cells[addr_i] <= din_i;
    end

    assign rd_bit_o = cells[addr_i];

    // R2: no write enable means the whole array holds
    assert_array_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(cells));

    // R3: a write lands at the sampled address
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (cells[$past(addr_i)] == $past(din_i)));
endmodule

// File: rtl/bitram_outreg.sv
module bitram_outreg
    import bitram_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en_i,
    input  bitram_state_t st_d_i,
    input  logic          rd_bit_i,
    input  logic          din_i,
    output logic          q_o,
    output logic          qn_o
);
    logic bit_sel;

    always_comb begin
        unique case (st_d_i)
            ST_WRITE: bit_sel = din_i;
            ST_READ:  bit_sel = rd_bit_i;
            default:  bit_sel = q_o;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o  <= 1'b0;
            qn_o <= 1'b1;
        end else if (ld_en_i) begin
            q_o  <= bit_sel;
            qn_o <= ~bit_sel;
        end
    end

    // R5: a write echoes the incoming data
    assert_write_echo_R5: assert property (@(posedge clk) disable iff (rst)
        (st_d_i == ST_WRITE) |=> (q_o == $past(din_i)) && (qn_o != $past(din_i)));
endmodule

// File: rtl/bitram_cmp.sv
module bitram_cmp
    import bitram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              q,
    output logic              q_oe,
    output logic              qn,
    output logic              qn_oe
);
    bitram_state_t st_d;
    bitram_state_t st_q;
    logic          wr_en;
    logic          ld_en;
    logic          rd_bit;

    bitram_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cs_n_i  (cs_n),
        .we_i    (we),
        .st_d_o  (st_d),
        .st_q_o  (st_q),
        .wr_en_o (wr_en),
        .ld_en_o (ld_en)
    );

    bitram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .wr_en_i  (wr_en),
        .addr_i   (addr),
        .din_i    (din),
        .rd_bit_o (rd_bit)
    );

    bitram_outreg u_out (
        .clk      (clk),
        .rst      (rst),
        .ld_en_i  (ld_en),
        .st_d_i   (st_d),
        .rd_bit_i (rd_bit),
        .din_i    (din),
        .q_o      (q),
        .qn_o     (qn)
    );

    assign q_oe  = (st_q != ST_IDLE);
    assign qn_oe = (st_q != ST_IDLE);

    // R7: enables agree and enabled values are complementary
    assert_oe_pair_R7: assert property (@(posedge clk) disable iff (rst)
        q_oe == qn_oe);
    assert_compl_R7: assert property (@(posedge clk) disable iff (rst)
        (q_oe && qn_oe) |-> (q != qn));

    // R2: deselect turns both drivers off at the next edge
    assert_float_R2: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!q_oe && !qn_oe));
endmodule

// File: tb/sim_bitram_cmp.sv
module sim_bitram_cmp;
    logic       clk = 1'b0;
    logic       rst;
    logic       cs_n;
    logic       we;
    logic [7:0] addr;
    logic       din;
    logic       q, q_oe, qn, qn_oe;

    int checks = 0;
    int errors = 0;
    logic ref_mem [256];
    logic known   [256];

    always #5 clk = ~clk;

    bitram_cmp u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .we(we), .addr(addr), .din(din),
        .q(q), .q_oe(q_oe), .qn(qn), .qn_oe(qn_oe)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, sample 1 ns after the rising edge
    task automatic cyc(input logic c, input logic w, input logic [7:0] a, input logic d);
        @(negedge clk);
        cs_n = c; we = w; addr = a; din = d;
        @(posedge clk);
        #1;
        if (!c && w) begin ref_mem[a] = d; known[a] = 1'b1; end
    endtask

    task automatic do_read(input string req, input logic [7:0] a);
        cyc(1'b0, 1'b0, a, 1'b0);
        chk(req, {q, qn, q_oe, qn_oe}, {ref_mem[a], ~ref_mem[a], 2'b11});
    endtask

    task automatic t_reset;
        rst = 1'b1; cs_n = 1'b0; we = 1'b0; addr = '0; din = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R8 reset enables", {2'b00, q_oe, qn_oe}, 4'b0000);
        @(negedge clk); rst = 1'b0; cs_n = 1'b1;
    endtask

    task automatic t_write_read;
        cyc(1'b0, 1'b1, 8'd0, 1'b1);
        cyc(1'b0, 1'b1, 8'd255, 1'b0);
        cyc(1'b0, 1'b1, 8'd1, 1'b0);
        cyc(1'b0, 1'b1, 8'd254, 1'b1);
        do_read("R1 addr0", 8'd0);
        do_read("R1 addr255", 8'd255);
        do_read("R4 addr1", 8'd1);
        do_read("R4 addr254", 8'd254);
    endtask

    task automatic t_echo;
        cyc(1'b0, 1'b1, 8'd77, 1'b1);
        chk("R5 echo one", {q, qn, q_oe, qn_oe}, 4'b1011);
        cyc(1'b0, 1'b1, 8'd77, 1'b0);
        chk("R5 echo zero", {q, qn, q_oe, qn_oe}, 4'b0111);
        do_read("R3 stored", 8'd77);
    endtask

    task automatic t_inhibit;
        cyc(1'b0, 1'b1, 8'd10, 1'b1);
        cyc(1'b1, 1'b1, 8'd10, 1'b0);
        chk("R2 float w", {2'b00, q_oe, qn_oe}, 4'b0000);
        cyc(1'b1, 1'b0, 8'd10, 1'b0);
        chk("R2 float r", {2'b00, q_oe, qn_oe}, 4'b0000);
        do_read("R2 no write", 8'd10);
    endtask

    task automatic t_rmw;
        cyc(1'b0, 1'b1, 8'd42, 1'b0);
        cyc(1'b0, 1'b0, 8'd42, 1'b0);
        chk("R6 old", {q, qn, q_oe, qn_oe}, 4'b0111);
        cyc(1'b0, 1'b1, 8'd42, 1'b1);
        chk("R6 new", {q, qn, q_oe, qn_oe}, 4'b1011);
        do_read("R6 after", 8'd42);
    endtask

    task automatic t_reset_keeps;
        cyc(1'b0, 1'b1, 8'd200, 1'b1);
        cyc(1'b0, 1'b1, 8'd201, 1'b0);
        t_reset();
        do_read("R8 kept 200", 8'd200);
        do_read("R8 kept 201", 8'd201);
    endtask

    task automatic t_random;
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            logic       c, w, d;
            a = 8'($urandom_range(0, 15));
            c = ($urandom_range(0, 7) == 0);
            w = $urandom_range(0, 1) == 1;
            d = $urandom_range(0, 1) == 1;
            if (!c && !w && !known[a]) w = 1'b1;
            cyc(c, w, a, d);
            if (c)
                chk("R2 random float", {2'b00, q_oe, qn_oe}, 4'b0000);
            else
                chk("R7 random", {q, qn, q_oe, qn_oe}, {ref_mem[a], ~ref_mem[a], 2'b11});
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin ref_mem[i] = 1'b0; known[i] = 1'b0; end
        t_reset();
        t_write_read();
        t_echo();
        t_inhibit();
        t_rmw();
        t_reset_keeps();
        t_random();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule